// File: doc/BRIEF.md
# Privileged Status Read Trap Checker

This block decides what happens when software issues a coprocessor-style read of a windowed 32-bit status register. The register is a window onto the upper half of one 64-bit feature record. A select input picks the record from a small internal bank. For every recognised read, the block resolves one of three results: the read completes, the instruction is undefined, or the read is routed as a trap to a higher privilege level. A trap to a higher level comes in a 64-bit or a 32-bit form.

The result depends on four things. The first is the current privilege level (0 to 3). The second is which of levels 2 and 3 are active. The third is the register width each of those levels uses. The fourth is a set of trap-control bits. These are weighed in a fixed, level-dependent priority order in which the first match wins.

A request is a single-cycle pulse. One cycle later the block presents a one-hot outcome, a trap code and the read data, marked by a single-cycle response pulse. The record bank is loaded through a simple write port.

Top module: `feat_rd_trap_chk`

## Requirements
- R1: A request is recognised only when coprocessor = 15, opc1 = 0, crn = 5, crm = 4 and opc2 = 4. A request with any other encoding produces no response.
- R2: A recognised request yields a response-valid pulse exactly one cycle later, lasting one cycle. When no response is presented, and after reset, outcome, code and data are all zero.
- R3: A read at privilege level 0 always gives the undefined outcome.
- R4: The outcome is one-hot, and exactly one bit is set per response. The bit positions are: bit0 read completes, bit1 undefined, bit2 trap to level 2 (64-bit form), bit3 trap to level 2 (32-bit form), bit4 trap to level 3 (64-bit form), bit5 monitor trap.
- R5: At level 1 the checks are applied in this order, and the first match wins. (a) Level 3 present, undef-priority set and level-3 trap-error set give undefined. (b) Level 2 enabled with its group-5 trap bit set gives a level-2 trap. (c) Level 2 enabled with its trap-error bit set gives a level-2 trap. (d) Level 3 present with its trap-error bit set follows R7. (e) If none of these match, the read completes.
- R6: A level-2 trap takes the 64-bit form when level 2 is 64-bit (l2_is64_i=1), and the 32-bit form otherwise.
- R7: When check (d) matches, the secure-debug undef bit gives undefined. Otherwise the result is the level-3 64-bit trap when level 3 is 64-bit, and the monitor trap when it is 32-bit. At level 1, if the current mode is monitor mode, the 32-bit case completes the read instead.
- R8: At level 2 only checks (a) and (d) apply, and the monitor-mode exemption is not used.
- R9: At level 3 the read gives the monitor trap when trap-error is set and the mode is not monitor mode. Otherwise the read completes.
- R10: A completed read returns bits [63:32] of the record whose index equals the select input.
- R11: The data is zero when the select value is greater than or equal to the record count input, when it is at or beyond the bank depth, or when the outcome is not read-completes.
- R12: The trap code is 0x03 for both level-2 trap forms and for the level-3 64-bit trap. It is 0x00 for every other outcome.
- R13: A load pulse writes its 64-bit data into the record at the load index. Later reads see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request pulse |
| cp_num_i | input | 4 | Coprocessor number |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| opc2_i | input | 3 | Second opcode field |
| cur_lvl_i | input | 2 | Current privilege level |
| l3_present_i | input | 1 | Level 3 implemented |
| hyp_en_i | input | 1 | Level 2 enabled |
| l2_is64_i | input | 1 | Level 2 uses 64-bit registers |
| l3_is64_i | input | 1 | Level 3 uses 64-bit registers |
| mon_mode_i | input | 1 | Current mode is monitor mode |
| l3_undef_prio_i | input | 1 | Level-3 undef-priority flag |
| l3_sdd_undef_i | input | 1 | Secure-debug undef flag |
| l3_terr_i | input | 1 | Level-3 trap-error bit |
| hyp_grp5_trap_i | input | 1 | Level-2 group-5 trap bit |
| hyp_terr_i | input | 1 | Level-2 trap-error bit |
| sel_i | input | SEL_W | Record select |
| rec_cnt_i | input | SEL_W+1 | Number of records reported |
| ld_en_i | input | 1 | Record load strobe |
| ld_idx_i | input | $clog2(NUM_REC) | Record load index |
| ld_data_i | input | 64 | Record load data |
| rsp_valid_o | output | 1 | Response pulse |
| outcome_o | output | 6 | One-hot outcome |
| trap_code_o | output | 8 | Trap code |
| rd_data_o | output | 32 | Read data |

## Verification
The hardest case to reach is a read where several trap checks match at once, so that only the priority order decides the outcome. Examples are the undef-priority check hiding an enabled level-2 trap, and the monitor-mode exemption at level 1 against its absence at level 2. The vector table holds rows that set several control bits together, and each row names the single outcome the ordering predicts. The level-3 rows also set undef flags to show that level 3 ignores them. Separate directed tests place the select value on both sides of the record count and of the bank depth.

// File: rtl/feat_trap_pkg.sv
package feat_trap_pkg;
  typedef enum logic [2:0] {
    OC_OK    = 3'd0,
    OC_UNDEF = 3'd1,
    OC_L2_64 = 3'd2,
    OC_L2_32 = 3'd3,
    OC_L3_64 = 3'd4,
    OC_MON   = 3'd5
  } oc_e;

  localparam int unsigned OC_W = 6;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_SYS = 8'h03;

  typedef struct packed {
    logic [1:0] lvl;
    logic l3_present;
    logic hyp_en;
    logic l2_is64;
    logic l3_is64;
    logic mon_mode;
    logic l3_undef_prio;
    logic l3_sdd_undef;
    logic l3_terr;
    logic hyp_grp5_trap;
    logic hyp_terr;
  } acc_ctx_t;
endpackage

// File: rtl/feat_enc_dec.sv
module feat_enc_dec (
  input  logic [3:0] cp_num_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o
);
  localparam logic [3:0] CP  = 4'd15;
  localparam logic [2:0] OP1 = 3'd0;
  localparam logic [3:0] CRN = 4'd5;
  localparam logic [3:0] CRM = 4'd4;
  localparam logic [2:0] OP2 = 3'd4;

  assign hit_o = (cp_num_i == CP) && (opc1_i == OP1) && (crn_i == CRN) &&
                 (crm_i == CRM) && (opc2_i == OP2);
endmodule

// File: rtl/feat_trap_prio.sv
module feat_trap_prio
  import feat_trap_pkg::*;
(
  input  acc_ctx_t            ctx_i,
  output logic [OC_W-1:0]     oc_o,
  output logic [CODE_W-1:0]   code_o
);
  oc_e sel;
  logic l3_undef_hit, l3_terr_hit;

  assign l3_undef_hit = ctx_i.l3_present && ctx_i.l3_undef_prio && ctx_i.l3_terr;
  assign l3_terr_hit  = ctx_i.l3_present && ctx_i.l3_terr;

  // result of the level-3 trap-error check; exempt selects the monitor-mode escape
  function automatic oc_e l3_route(input acc_ctx_t c, input logic exempt);
    if (c.l3_sdd_undef)          return OC_UNDEF;
    if (c.l3_is64)               return OC_L3_64;
    if (exempt && c.mon_mode)    return OC_OK;
    return OC_MON;
  endfunction

  always_comb begin
    sel = OC_OK;
    unique case (ctx_i.lvl)
      2'd0: sel = OC_UNDEF;
      2'd1: begin
        if (l3_undef_hit)                              sel = OC_UNDEF;
        else if (ctx_i.hyp_en && ctx_i.hyp_grp5_trap)  sel = ctx_i.l2_is64 ? OC_L2_64 : OC_L2_32;
        else if (ctx_i.hyp_en && ctx_i.hyp_terr)       sel = ctx_i.l2_is64 ? OC_L2_64 : OC_L2_32;
        else if (l3_terr_hit)                          sel = l3_route(ctx_i, 1'b1);
        else                                           sel = OC_OK;
      end
      2'd2: begin
        if (l3_undef_hit)      sel = OC_UNDEF;
        else if (l3_terr_hit)  sel = l3_route(ctx_i, 1'b0);
        else                   sel = OC_OK;
      end
      default: sel = (ctx_i.l3_terr && !ctx_i.mon_mode) ? OC_MON : OC_OK;
    endcase
  end

  assign oc_o   = OC_W'(1) << sel;
  assign code_o = (sel == OC_L2_64 || sel == OC_L2_32 || sel == OC_L3_64) ? CODE_SYS : '0;

  always_comb begin
    assert ($onehot(oc_o)) else $error("p_onehot_r4 comb");
  end
endmodule

// File: rtl/feat_rec_bank.sv
module feat_rec_bank #(
  parameter int unsigned NUM_REC = 8,
  parameter int unsigned SEL_W   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_REC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [63:0]      ld_data_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W:0]   cnt_i,
  output logic [31:0]      hi_o
);
  localparam logic [SEL_W:0] DEPTH = (SEL_W+1)'(NUM_REC);

  logic [63:0] rec_q [NUM_REC];
  logic        in_range;

  for (genvar g = 0; g < NUM_REC; g++) begin : g_rec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         rec_q[g] <= '0;
      else if (ld_en_i && ld_idx_i == IDX_W'(g))           rec_q[g] <= ld_data_i;
    end
  end

  assign in_range = ({1'b0, sel_i} < cnt_i) && ({1'b0, sel_i} < DEPTH);
  assign hi_o     = in_range ? rec_q[sel_i[IDX_W-1:0]][63:32] : '0;
endmodule

// File: rtl/feat_rd_trap_chk.sv
module feat_rd_trap_chk
  import feat_trap_pkg::*;
#(
  parameter int unsigned NUM_REC = 8,
  parameter int unsigned SEL_W   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_REC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [3:0]         cp_num_i,
  input  logic [2:0]         opc1_i,
  input  logic [3:0]         crn_i,
  input  logic [3:0]         crm_i,
  input  logic [2:0]         opc2_i,
  input  logic [1:0]         cur_lvl_i,
  input  logic               l3_present_i,
  input  logic               hyp_en_i,
  input  logic               l2_is64_i,
  input  logic               l3_is64_i,
  input  logic               mon_mode_i,
  input  logic               l3_undef_prio_i,
  input  logic               l3_sdd_undef_i,
  input  logic               l3_terr_i,
  input  logic               hyp_grp5_trap_i,
  input  logic               hyp_terr_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [SEL_W:0]     rec_cnt_i,
  input  logic               ld_en_i,
  input  logic [IDX_W-1:0]   ld_idx_i,
  input  logic [63:0]        ld_data_i,
  output logic               rsp_valid_o,
  output logic [OC_W-1:0]    outcome_o,
  output logic [CODE_W-1:0]  trap_code_o,
  output logic [31:0]        rd_data_o
);
  logic                enc_hit, fire;
  acc_ctx_t            ctx;
  logic [OC_W-1:0]     oc_d;
  logic [CODE_W-1:0]   code_d;
  logic [31:0]         hi_d;

  assign ctx = '{lvl: cur_lvl_i, l3_present: l3_present_i, hyp_en: hyp_en_i,
                 l2_is64: l2_is64_i, l3_is64: l3_is64_i, mon_mode: mon_mode_i,
                 l3_undef_prio: l3_undef_prio_i, l3_sdd_undef: l3_sdd_undef_i,
                 l3_terr: l3_terr_i, hyp_grp5_trap: hyp_grp5_trap_i,
                 hyp_terr: hyp_terr_i};

  feat_enc_dec u_dec (
    .cp_num_i(cp_num_i), .opc1_i(opc1_i), .crn_i(crn_i),
    .crm_i(crm_i), .opc2_i(opc2_i), .hit_o(enc_hit)
  );

  feat_trap_prio u_prio (.ctx_i(ctx), .oc_o(oc_d), .code_o(code_d));

  feat_rec_bank #(.NUM_REC(NUM_REC), .SEL_W(SEL_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_data_i(ld_data_i), .sel_i(sel_i), .cnt_i(rec_cnt_i), .hi_o(hi_d)
  );

  assign fire = req_valid_i && enc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      outcome_o   <= '0;
      trap_code_o <= '0;
      rd_data_o   <= '0;
    end else begin
      rsp_valid_o <= fire;
      outcome_o   <= fire ? oc_d : '0;
      trap_code_o <= fire ? code_d : '0;
      rd_data_o   <= (fire && oc_d[OC_OK]) ? hi_d : '0;
    end
  end

  p_rsp_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);
  p_no_rsp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !rsp_valid_o && outcome_o == '0);
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones(outcome_o) == 1);
  p_lvl0_undef_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cur_lvl_i == 2'd0 |=> outcome_o[OC_UNDEF]);
  p_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (outcome_o[OC_L2_64] || outcome_o[OC_L2_32] || outcome_o[OC_L3_64])
      |-> trap_code_o == CODE_SYS);
  p_data_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !outcome_o[OC_OK] |-> rd_data_o == '0);
  p_lvl3_mon_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && cur_lvl_i == 2'd3 && l3_terr_i && !mon_mode_i |=> outcome_o[OC_MON]);
endmodule

// File: tb/feat_rd_trap_chk_test.sv
module feat_rd_trap_chk_test;
  localparam int NUM_REC = 8;
  localparam int SEL_W = 4;
  localparam int NV = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req = 1'b0;
  logic [3:0] cp = 4'd15, crn = 4'd5, crm = 4'd4;
  logic [2:0] op1 = 3'd0, op2 = 3'd4;
  logic [1:0] lvl = '0;
  logic [9:0] f = '0; // l3p hyp l2w l3w mon up sdd l3t g5 ht
  logic [SEL_W-1:0] sel = '0;
  logic [SEL_W:0] cnt = '0;
  logic ld_en = 1'b0;
  logic [2:0] ld_idx = '0;
  logic [63:0] ld_data = '0;
  logic rsp_v;
  logic [5:0] oc;
  logic [7:0] code;
  logic [31:0] rdat;

  feat_rd_trap_chk #(.NUM_REC(NUM_REC), .SEL_W(SEL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .cp_num_i(cp), .opc1_i(op1),
    .crn_i(crn), .crm_i(crm), .opc2_i(op2), .cur_lvl_i(lvl),
    .l3_present_i(f[9]), .hyp_en_i(f[8]), .l2_is64_i(f[7]), .l3_is64_i(f[6]),
    .mon_mode_i(f[5]), .l3_undef_prio_i(f[4]), .l3_sdd_undef_i(f[3]),
    .l3_terr_i(f[2]), .hyp_grp5_trap_i(f[1]), .hyp_terr_i(f[0]),
    .sel_i(sel), .rec_cnt_i(cnt), .ld_en_i(ld_en), .ld_idx_i(ld_idx),
    .ld_data_i(ld_data), .rsp_valid_o(rsp_v), .outcome_o(oc),
    .trap_code_o(code), .rd_data_o(rdat)
  );

  localparam logic [5:0] OK = 6'b000001, UD = 6'b000010, T2W = 6'b000100,
                         T2N = 6'b001000, T3W = 6'b010000, MON = 6'b100000;

  // {level, flags, expected outcome}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 10'b0000000000, UD},   // R3
    {2'd0, 10'b1111111111, UD},   // R3
    {2'd1, 10'b0000000000, OK},   // R5
    {2'd1, 10'b1100010110, UD},   // R5 undef-priority first
    {2'd1, 10'b1110000110, T2W},  // R5 R6 group-5 before level 3
    {2'd1, 10'b0100000010, T2N},  // R6
    {2'd1, 10'b0110000001, T2W},  // R5 hyp trap-error
    {2'd1, 10'b0000000011, OK},   // R5 hyp disabled
    {2'd1, 10'b1000001100, UD},   // R7 secure-debug undef
    {2'd1, 10'b1001000100, T3W},  // R7
    {2'd1, 10'b1000000100, MON},  // R7
    {2'd1, 10'b1000100100, OK},   // R7 monitor exemption
    {2'd1, 10'b0000000100, OK},   // R5 level 3 absent
    {2'd2, 10'b0100000011, OK},   // R8 hyp checks skipped
    {2'd2, 10'b1000100100, MON},  // R8 no exemption
    {2'd2, 10'b1000010100, UD},   // R8
    {2'd2, 10'b1001000100, T3W},  // R8
    {2'd3, 10'b0000000100, MON},  // R9
    {2'd3, 10'b0000100100, OK},   // R9
    {2'd3, 10'b1000011100, MON},  // R9 undef flags ignored
    {2'd2, 10'b1001001100, UD}    // R8 R7
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [63:0] pat(input int i);
    return {32'hC0DE_0000 | 32'(i), 32'h5A5A_0000 | 32'(i)};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic issue();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset", {rsp_v, oc, code, rdat}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < NUM_REC; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_idx = 3'(i); ld_data = pat(i);
    end
    @(negedge clk); ld_en = 1'b0;

    sel = 4'd1; cnt = 5'd4;
    for (int v = 0; v < NV; v++) begin
      logic [5:0] e;
      e = VEC[v][5:0];
      lvl = VEC[v][17:16]; f = VEC[v][15:6];
      issue();
      chk("R4 R5 R7 R8 R9 outcome", {57'd0, rsp_v, oc}, {57'd0, 1'b1, e});
      chk("R12 code", 64'(code), ((e == T2W) || (e == T2N) || (e == T3W)) ? 64'h3 : 64'h0);
      chk("R10 R11 data", 64'(rdat), (e == OK) ? 64'(pat(1) >> 32) : 64'h0);
    end

    // R2 single pulse
    @(negedge clk);
    chk("R2 pulse end", {rsp_v, oc, code, rdat}, '0);

    // R1 other encodings
    lvl = 2'd1; f = '0;
    crm = 4'd3; issue();
    chk("R1 crm", 64'(rsp_v), 64'h0);
    crm = 4'd4; cp = 4'd14; issue();
    chk("R1 cp", 64'(rsp_v), 64'h0);
    cp = 4'd15; op2 = 3'd0; issue();
    chk("R1 opc2", 64'(rsp_v), 64'h0);
    op2 = 3'd4;

    // R10 last in-range record
    sel = 4'd3; cnt = 5'd4; issue();
    chk("R10 sel=cnt-1", 64'(rdat), 64'(pat(3) >> 32));
    // R11 select at count
    sel = 4'd4; issue();
    chk("R11 sel=cnt", {rsp_v, oc, rdat}, {1'b1, OK, 32'h0});
    // R11 zero count
    sel = 4'd0; cnt = 5'd0; issue();
    chk("R11 cnt=0", 64'(rdat), 64'h0);
    // R11 beyond depth
    sel = 4'd9; cnt = 5'd15; issue();
    chk("R11 depth", 64'(rdat), 64'h0);
    sel = 4'd7; issue();
    chk("R10 top record", 64'(rdat), 64'(pat(7) >> 32));

    // R13 reload one record
    @(negedge clk); ld_en = 1'b1; ld_idx = 3'd2; ld_data = 64'hFACE_B00C_0123_4567;
    @(negedge clk); ld_en = 1'b0;
    sel = 4'd2; cnt = 5'd8; issue();
    chk("R13 reload", 64'(rdat), 64'hFACE_B00C);

    // R2 back-to-back requests
    @(negedge clk); req = 1'b1; lvl = 2'd0;
    @(negedge clk); lvl = 2'd3; f = 10'b0000000100;
    chk("R2 b2b first", {57'd0, rsp_v, oc}, {57'd0, 1'b1, UD});
    @(negedge clk); req = 1'b0;
    chk("R2 b2b second", {57'd0, rsp_v, oc}, {57'd0, 1'b1, MON});
    @(negedge clk);
    chk("R2 b2b idle", 64'(rsp_v), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule